// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block walks an 8-entry low-register list and moves one 32-bit word per accepted memory request between the register file and memory. It serves four transfer kinds: a stack push, a stack pop, a multiple store through a named base register and a multiple load through a named base register. A push can add the link register as one more entry. A pop can add the program counter as one more entry. The block drives the register-file read index and write port, a simple request/ready memory port, the final base or stack-pointer value, and a one-cycle completion pulse.

The caller presents the transfer kind, the list, the extra-entry flag, the base register index and the current base value together with a one-cycle `start`. The block captures them and raises `busy`. It then issues the words in ascending address order. After the last word it writes back the base and pulses `done`, together with the cost of the transfer split into sequential, non-sequential and internal cycles. When a pop loads the program counter, `flush` is raised in the same cycle as `done`.

Top module: `blk_xfer_seq`

## Requirements
- R1: Words go in ascending address order, 4 bytes apart, and the lowest-numbered listed register takes the lowest address.
- R2: Push (kind 2'b00) starts at base minus 4 times the total entry count. The link register (index 14), when selected, takes the highest address. The stack pointer (index 13) is written back as base minus 4 times the total.
- R3: Pop (kind 2'b01) reads upward from the stack pointer. The program counter (index 15), when selected, is loaded last. The stack pointer becomes base plus 4 times the total, and `flush` pulses with `done` only when the program counter was loaded.
- R4: Multiple store (kind 2'b10) stores the original base value for a base register that is in the list. The base is written back as base plus 4 times the list count.
- R5: Multiple load (kind 2'b11) writes the base back as base plus 4 times the list count in the `done` cycle, after all loads. This write wins over a loaded value for the same register. The extra-entry flag is ignored for kinds 2'b10 and 2'b11.
- R6: On any load, only listed registers (plus the program counter when selected) and the base are written. Every other register keeps its value.
- R7: The low two bits of `mem_addr` are always zero. The written-back base keeps the unaligned arithmetic.
- R8: An empty list with no extra entry makes no memory request, and `done` follows one clock edge after `start` is captured.
- R9: With `mem_ready` held high, `done` is high after total+1 clock edges counted from the capture of `start`. `cost_s`, `cost_n` and `cost_i` are valid with `done`:
  - push: S = total-1, N = 2, I = 0
  - multiple store: S = n-1, N = 2, I = 0
  - multiple load or pop without the program counter: S = n, N = 1, I = 1
  - pop with the program counter: S = n+2, N = 2, I = 1
  - empty transfer: all three are zero
- R10: While `mem_ready` is low, the request, its address and its direction hold steady.
- R11: A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (captured only when idle) |
| kind | input | 2 | 00 push, 01 pop, 10 multiple store, 11 multiple load |
| reg_list | input | 8 | Low-register list, bit i selects register i |
| extra | input | 1 | Add link register (push) or program counter (pop) |
| base_idx | input | 4 | Base register index for multiple store/load |
| base_val | input | 32 | Current base or stack-pointer value |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned request address |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Load data, valid with `mem_ready` |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| done | output | 1 | One-cycle completion pulse |
| flush | output | 1 | Program counter was loaded; pipeline must refill |
| cost_s | output | 5 | Sequential cycle count |
| cost_n | output | 5 | Non-sequential cycle count |
| cost_i | output | 5 | Internal cycle count |

## Verification
The assertions assume that `mem_rdata` is valid in the cycle `mem_ready` is high and that `rf_rd_data` answers `rf_rd_idx` in the same cycle. They also assume that `start` is a single-cycle pulse. The bench keeps to this with a combinational register and memory model that answers in the same cycle. It drives `start` for exactly one cycle at the falling edge. Back-pressure comes only from a ready line that toggles on each rising edge, so a stalled request is always accepted within two cycles.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int WORD_W = 32,
  parameter int LIST_W = 8,
  parameter int SP_IDX = 13,
  parameter int LR_IDX = 14,
  parameter int PC_IDX = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        kind,
  input  logic [LIST_W-1:0] reg_list,
  input  logic              extra,
  input  logic [3:0]        base_idx,
  input  logic [WORD_W-1:0] base_val,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [3:0]        rf_rd_idx,
  input  logic [WORD_W-1:0] rf_rd_data,
  output logic              rf_we,
  output logic [3:0]        rf_wr_idx,
  output logic [WORD_W-1:0] rf_wdata,
  output logic              done,
  output logic              flush,
  output logic [4:0]        cost_s,
  output logic [4:0]        cost_n,
  output logic [4:0]        cost_i
);
  localparam int MASK_W = LIST_W + 1;
  localparam int POS_W  = $clog2(MASK_W + 1);
  localparam int CNT_W  = 5;
  localparam logic [1:0] K_PUSH = 2'b00;
  localparam logic [1:0] K_POP  = 2'b01;
  localparam logic [1:0] K_STM  = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_FIN} st_t;

  st_t               state;
  logic [1:0]        kind_q;
  logic [MASK_W-1:0] mask_q;
  logic [WORD_W-1:0] addr_q, final_q, orig_q;
  logic [3:0]        wb_q;
  logic              pcx_q;
  logic [CNT_W-1:0]  s_q, n_q, i_q;

  logic              go, accept, ext_en, pcx;
  logic [CNT_W-1:0]  lst_cnt, tot, nxt_s, nxt_n, nxt_i;
  logic [WORD_W-1:0] span;
  logic [MASK_W-1:0] low_hot, mask_nxt;
  logic [POS_W-1:0]  low_pos;
  logic [3:0]        cur_idx;

  assign go      = start && (state == ST_IDLE);
  assign ext_en  = extra && !kind[1];
  assign pcx     = (kind == K_POP) && extra;
  assign mem_req = (state == ST_XFER);
  assign accept  = mem_req && mem_ready;
  assign done    = (state == ST_FIN);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    lst_cnt = '0;
    for (int i = 0; i < LIST_W; i++)
      lst_cnt = lst_cnt + CNT_W'(reg_list[i]);
    tot  = lst_cnt + CNT_W'(ext_en);
    span = WORD_W'(tot) << 2;
  end

  always_comb begin
    nxt_s = '0;
    nxt_n = '0;
    nxt_i = '0;
    if (tot != '0) begin
      if (!kind[0]) begin
        nxt_s = tot - CNT_W'(1);
        nxt_n = CNT_W'(2);
      end else begin
        nxt_s = tot + CNT_W'(pcx);
        nxt_n = CNT_W'(1) + CNT_W'(pcx);
        nxt_i = CNT_W'(1);
      end
    end
  end

  always_comb begin
    low_hot = '0;
    low_pos = '0;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (mask_q[i]) begin
        low_hot = MASK_W'(1) << i;
        low_pos = POS_W'(i);
      end
    end
  end

  assign mask_nxt = mask_q & ~low_hot;
  assign cur_idx  = (low_pos == POS_W'(LIST_W))
                  ? ((kind_q == K_PUSH) ? 4'(LR_IDX) : 4'(PC_IDX))
                  : 4'(low_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind_q  <= '0;
      mask_q  <= '0;
      addr_q  <= '0;
      final_q <= '0;
      orig_q  <= '0;
      wb_q    <= '0;
      pcx_q   <= 1'b0;
      s_q     <= '0;
      n_q     <= '0;
      i_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          kind_q  <= kind;
          mask_q  <= {ext_en, reg_list};
          addr_q  <= (kind == K_PUSH) ? base_val - span : base_val;
          final_q <= (kind == K_PUSH) ? base_val - span : base_val + span;
          orig_q  <= base_val;
          wb_q    <= kind[1] ? base_idx : 4'(SP_IDX);
          pcx_q   <= pcx;
          s_q     <= nxt_s;
          n_q     <= nxt_n;
          i_q     <= nxt_i;
          state   <= (tot == '0) ? ST_FIN : ST_XFER;
        end
        ST_XFER: if (accept) begin
          mask_q <= mask_nxt;
          addr_q <= addr_q + WORD_W'(4);
          if (mask_nxt == '0) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_we    = mem_req && !kind_q[0];
  assign mem_addr  = {addr_q[WORD_W-1:2], 2'b00};
  assign rf_rd_idx = cur_idx;
  assign mem_wdata = (kind_q == K_STM && cur_idx == wb_q) ? orig_q : rf_rd_data;
  assign rf_we     = (accept && kind_q[0]) || done;
  assign rf_wr_idx = done ? wb_q : cur_idx;
  assign rf_wdata  = done ? final_q : mem_rdata;
  assign flush     = done && pcx_q;
  assign cost_s    = s_q;
  assign cost_n    = n_q;
  assign cost_i    = i_q;
endmodule

module blk_xfer_seq_chk #(
  parameter int WORD_W = 32,
  parameter int LIST_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        kind,
  input logic [LIST_W-1:0] reg_list,
  input logic              extra,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_addr,
  input logic              mem_ready,
  input logic              rf_we,
  input logic              done,
  input logic              flush
);
  assert_ascend_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (!mem_req || mem_addr == $past(mem_addr) + WORD_W'(4)));
  assert_flush_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> done);
  assert_wb_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rf_we);
  assert_write_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (done || (mem_req && mem_ready && !mem_we)));
  assert_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  assert_empty_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && reg_list == '0 && (!extra || kind[1])) |=> (done && !mem_req));
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.WORD_W(WORD_W), .LIST_W(LIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .reg_list(reg_list),
  .extra(extra), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ready(mem_ready), .rf_we(rf_we), .done(done),
  .flush(flush)
);

// File: tb/blk_xfer_seq_tb.sv
`timescale 1ns/1ps
module blk_xfer_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, extra = 1'b0;
  logic [1:0] kind = '0;
  logic [7:0] reg_list = '0;
  logic [3:0] base_idx = '0;
  logic [31:0] base_val = '0;
  logic busy, mem_req, mem_we, mem_ready, rf_we, done, flush;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wdata;
  logic [3:0] rf_rd_idx, rf_wr_idx;
  logic [4:0] cost_s, cost_n, cost_i;

  logic [31:0] rf [16];
  logic [31:0] mem [64];
  logic stall_en = 1'b0, tog = 1'b0, req_seen = 1'b0;
  int checks = 0, fails = 0;
  int edges;
  logic [4:0] got_s, got_n, got_i;
  logic got_flush;

  always #2.5 clk = ~clk;

  assign mem_ready  = stall_en ? tog : 1'b1;
  assign mem_rdata  = mem[mem_addr[7:2]];
  assign rf_rd_data = rf[rf_rd_idx];

  always @(posedge clk) begin
    tog <= ~tog;
    if (mem_req) req_seen <= 1'b1;
    if (mem_req && mem_ready && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    if (rf_we) rf[rf_wr_idx] <= rf_wdata;
  end

  blk_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .reg_list(reg_list),
    .extra(extra), .base_idx(base_idx), .base_val(base_val), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .rf_rd_idx(rf_rd_idx),
    .rf_rd_data(rf_rd_data), .rf_we(rf_we), .rf_wr_idx(rf_wr_idx),
    .rf_wdata(rf_wdata), .done(done), .flush(flush), .cost_s(cost_s),
    .cost_n(cost_n), .cost_i(cost_i)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic preset_rf();
    for (int i = 0; i < 16; i++) rf[i] = 32'h5A00_0000 + i;
  endtask

  task automatic run(input logic [1:0] k, input logic [7:0] lst, input logic ex,
                     input logic [3:0] bi, input logic [31:0] bv, input bit inject);
    @(negedge clk);
    kind = k; reg_list = lst; extra = ex; base_idx = bi; base_val = bv;
    req_seen = 1'b0; start = 1'b1;
    edges = 0;
    @(negedge clk); edges++;
    start = 1'b0;
    if (inject && !done) begin
      @(negedge clk); edges++;
      kind = 2'b10; reg_list = 8'hFF; base_val = 32'h0; start = 1'b1;
      @(negedge clk); edges++;
      start = 1'b0; kind = k; reg_list = lst; base_val = bv;
    end
    while (!done && edges < 300) begin
      @(negedge clk); edges++;
    end
    got_s = cost_s; got_n = cost_n; got_i = cost_i; got_flush = flush;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11", "busy after reset", 32'(busy), 0);
    chk("R8", "mem_req after reset", 32'(mem_req), 0);
    chk("R8", "done after reset", 32'(done), 0);
  endtask

  task automatic t_push();
    preset_rf();
    run(2'b00, 8'b1101_0011, 1'b0, 4'd0, 32'h94, 0);
    chk("R1", "push word0", mem[32], rf[0]);
    chk("R1", "push word1", mem[33], rf[1]);
    chk("R1", "push word2", mem[34], rf[4]);
    chk("R1", "push word3", mem[35], rf[6]);
    chk("R1", "push word4", mem[36], rf[7]);
    chk("R2", "push sp", rf[13], 32'h80);
    chk("R9", "push edges", edges, 6);
    chk("R9", "push cost", {got_s, got_n, got_i}, {5'd4, 5'd2, 5'd0});
  endtask

  task automatic t_push_lr();
    preset_rf();
    run(2'b00, 8'b1101_0011, 1'b1, 4'd0, 32'hC0, 0);
    chk("R2", "push lr lowest", mem[42], rf[0]);
    chk("R2", "push lr at top", mem[47], rf[14]);
    chk("R2", "push lr sp", rf[13], 32'hA8);
    chk("R9", "push lr edges", edges, 7);
    chk("R9", "push lr cost", {got_s, got_n, got_i}, {5'd5, 5'd2, 5'd0});
  endtask

  task automatic t_pop_pc();
    preset_rf();
    for (int i = 0; i < 6; i++) mem[48 + i] = 32'hC0DE_0000 + i;
    stall_en = 1'b1;
    run(2'b01, 8'b1101_0011, 1'b1, 4'd0, 32'hC0, 1);
    stall_en = 1'b0;
    chk("R3", "pop r0", rf[0], 32'hC0DE_0000);
    chk("R3", "pop r4", rf[4], 32'hC0DE_0002);
    chk("R3", "pop r7", rf[7], 32'hC0DE_0004);
    chk("R3", "pop pc last", rf[15], 32'hC0DE_0005);
    chk("R3", "pop sp", rf[13], 32'hD8);
    chk("R3", "pop flush", 32'(got_flush), 1);
    chk("R6", "pop r2 untouched", rf[2], 32'h5A00_0002);
    chk("R6", "pop r5 untouched", rf[5], 32'h5A00_0005);
    chk("R9", "pop pc cost", {got_s, got_n, got_i}, {5'd7, 5'd2, 5'd1});
    chk("R11", "busy after done", 32'(busy), 0);
    for (int i = 0; i < 8; i++) chk("R11", "no injected store", mem[i], 0);
  endtask

  task automatic t_pop_roundtrip();
    preset_rf();
    for (int i = 0; i < 8; i++) rf[i] = 0;
    run(2'b01, 8'b1101_0011, 1'b0, 4'd0, 32'h80, 0);
    chk("R3", "pop r1", rf[1], 32'h5A00_0001);
    chk("R3", "pop r6", rf[6], 32'h5A00_0006);
    chk("R6", "pop r3 untouched", rf[3], 0);
    chk("R3", "pop sp", rf[13], 32'h94);
    chk("R3", "no flush", 32'(got_flush), 0);
    chk("R9", "pop cost", {got_s, got_n, got_i}, {5'd5, 5'd1, 5'd1});
  endtask

  task automatic t_stm_base();
    preset_rf();
    rf[2] = 32'h40;
    run(2'b10, 8'b1101_0101, 1'b1, 4'd2, 32'h40, 0);
    chk("R4", "stm word0", mem[16], rf[0]);
    chk("R4", "stm original base", mem[17], 32'h40);
    chk("R4", "stm word4", mem[20], rf[7]);
    chk("R5", "stm ignores extra", mem[21], 0);
    chk("R4", "stm writeback", rf[2], 32'h54);
    chk("R9", "stm cost", {got_s, got_n, got_i}, {5'd4, 5'd2, 5'd0});
  endtask

  task automatic t_ldm_base();
    preset_rf();
    rf[2] = 32'h40;
    run(2'b11, 8'b1101_0101, 1'b0, 4'd2, 32'h40, 0);
    chk("R5", "ldm base wins", rf[2], 32'h54);
    chk("R5", "ldm r4", rf[4], mem[18]);
    chk("R6", "ldm r1 untouched", rf[1], 32'h5A00_0001);
    chk("R6", "ldm r5 untouched", rf[5], 32'h5A00_0005);
    chk("R9", "ldm cost", {got_s, got_n, got_i}, {5'd5, 5'd1, 5'd1});
  endtask

  task automatic t_unaligned();
    preset_rf();
    run(2'b10, 8'b0000_0011, 1'b0, 4'd5, 32'h63, 0);
    chk("R7", "aligned word0", mem[24], rf[0]);
    chk("R7", "aligned word1", mem[25], rf[1]);
    chk("R7", "raw writeback", rf[5], 32'h6B);
  endtask

  task automatic t_empty();
    preset_rf();
    run(2'b01, 8'h00, 1'b0, 4'd0, 32'h100, 0);
    chk("R8", "empty edges", edges, 1);
    chk("R8", "empty no request", 32'(req_seen), 0);
    chk("R9", "empty cost", {got_s, got_n, got_i}, 0);
    chk("R8", "empty sp", rf[13], 32'h100);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    preset_rf();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_push();
    t_push_lr();
    t_pop_pc();
    t_pop_roundtrip();
    t_stm_base();
    t_ldm_base();
    t_unaligned();
    t_empty();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule